// File: doc/BRIEF.md
# Banked GPIO Register Controller

A memory-mapped controller for a bank of general-purpose pins. The pin count is a parameter of either 64 or 96, and each feature of the bank takes one 32-bit word for every 32 pins. Software reaches the registers over a simple word-addressed bus that accepts one access per cycle. Reads are combinational and return data in the same cycle as the access. Writes take effect at the clock edge that accepts them.

The registers are grouped by feature. Each group spans NREG = PIN_COUNT/32 consecutive words, so where a group starts depends on the pin count. Word `g*NREG + k` holds feature group `g` for pins `32k` to `32k+31`. The groups, by number, are: 0 pin level, 1 direction, 2 set strobe, 3 clear strobe, 4 to 6 reserved for a separate edge-detection block, and 7 alternate function. The output latch is never written directly. It changes only through the set and clear strobe words. The alternate-function group packs 16 pins per word, so it spans 2*NREG words. Input pins pass through a two-flop synchroniser before software can read them.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: A read of word k (0 ≤ k < NREG) returns the input pins 32k..32k+31, as sampled through two register stages. Bit b is pin 32k+b, and every pin reads this way whatever its direction. Writes to these words change nothing.
- R2: Word NREG+k is the direction register for pins 32k..32k+31. A 1 makes the pin an output and drives its `pin_oe` bit high. A write replaces the word, and a read returns it.
- R3: Writing word 2*NREG+k sets `pin_out` high for every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R4: Writing word 3*NREG+k clears `pin_out` for every pin whose data bit is 1. Pins whose data bit is 0 keep their value.
- R5: Reads of the set and clear words return zero.
- R6: Word 7*NREG+j (0 ≤ j < 2*NREG) is the alternate-function register. Pin p is held in bits (p mod 16)*2+1 : (p mod 16)*2 of word p/16 and drives `alt_sel[2p+1:2p]`. The value 0 selects plain GPIO. A read returns the written word.
- R7: Reset clears `pin_out`, `pin_oe` and every alternate-function field.
- R8: Groups 4 to 6 and all addresses at or above 9*NREG read as zero, and writes to them change no output.
- R9: `pin_out`, `pin_oe` and `alt_sel` change at the clock edge that accepts the write. When a set and a clear for the same pin arrive in consecutive cycles, the later write decides the pin.
- R10: Cycles with no write access leave `pin_out`, `pin_oe` and `alt_sel` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| pin_in | input | PIN_COUNT | Raw input pin levels |
| pin_out | output | PIN_COUNT | Output latch |
| pin_oe | output | PIN_COUNT | Output enable, equal to the direction register |
| alt_sel | output | 2*PIN_COUNT | Alternate-function field per pin |

## Verification
Two functions can land in the same cycle: a strobe write that updates the output latch, and a change on the input pins that enters the synchroniser. The bench changes `pin_in` on the same edge that drives a set write. It then checks that `pin_out` moved immediately and that the level word shows the new inputs two edges later, unaffected by the write. Set and clear writes for one pin are also issued back to back in both orders, and the pin is judged after each pair to confirm that the later strobe decides it.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   // Feature groups in address order; the order is part of the map.
   typedef enum logic [2:0] {
      GRP_LEVEL = 3'd0,
      GRP_DIR   = 3'd1,
      GRP_SET   = 3'd2,
      GRP_CLR   = 3'd3,
      GRP_RISE  = 3'd4,
      GRP_FALL  = 3'd5,
      GRP_STAT  = 3'd6,
      GRP_ALT   = 3'd7
   } grp_e;

   localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned WIDTH  = 64,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("gpio_sync needs at least two stages");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= d_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NREG   = 2,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned IDX_W  = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output grp_e              grp,
   output logic [IDX_W-1:0]  idx,
   output logic              hit
);
   localparam int unsigned ALT_BASE = 7 * NREG;
   localparam int unsigned ALT_END  = 9 * NREG;

   always_comb begin
      int unsigned a;
      a   = 32'(addr);
      grp = GRP_LEVEL;
      idx = '0;
      hit = 1'b0;
      if (a < ALT_BASE) begin
         grp = grp_e'(3'(a / NREG));
         idx = IDX_W'(a % NREG);
         hit = 1'b1;
      end else if (a < ALT_END) begin
         grp = GRP_ALT;
         idx = IDX_W'(a - ALT_BASE);
         hit = 1'b1;
      end
   end
endmodule

// File: rtl/gpio_out_bank.sv
module gpio_out_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NREG  = 2,
   parameter int unsigned IDX_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  grp_e                   grp,
   input  logic [IDX_W-1:0]       idx,
   input  logic [WORD_W-1:0]      wdata,
   output logic [NREG*WORD_W-1:0] out_vec,
   output logic [NREG*WORD_W-1:0] dir_vec
);
   generate
      for (genvar w = 0; w < NREG; w++) begin : g_word
         logic [WORD_W-1:0] out_q, dir_q;
         logic              sel_w;
         assign sel_w = we && (idx == IDX_W'(w));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q <= '0;
               dir_q <= '0;
            end else if (sel_w) begin
               unique case (grp)
                  GRP_SET: out_q <= out_q | wdata;
                  GRP_CLR: out_q <= out_q & ~wdata;
                  GRP_DIR: dir_q <= wdata;
                  default: ;
               endcase
            end
         end

         assign out_vec[w*WORD_W +: WORD_W] = out_q;
         assign dir_vec[w*WORD_W +: WORD_W] = dir_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_alt_bank.sv
module gpio_alt_bank
   import gpio_bank_pkg::*;
#(
   parameter int unsigned NWORDS = 4,
   parameter int unsigned IDX_W  = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [IDX_W-1:0]         idx,
   input  logic [WORD_W-1:0]        wdata,
   output logic [NWORDS*WORD_W-1:0] alt_vec
);
   generate
      for (genvar w = 0; w < NWORDS; w++) begin : g_word
         logic [WORD_W-1:0] alt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        alt_q <= '0;
            else if (we && idx == IDX_W'(w))   alt_q <= wdata;
         end
         assign alt_vec[w*WORD_W +: WORD_W] = alt_q;
      end
   endgenerate
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int unsigned PIN_COUNT = 64,
   parameter int unsigned ADDR_W    = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_wr,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [31:0]            bus_wdata,
   output logic [31:0]            bus_rdata,
   input  logic [PIN_COUNT-1:0]   pin_in,
   output logic [PIN_COUNT-1:0]   pin_out,
   output logic [PIN_COUNT-1:0]   pin_oe,
   output logic [2*PIN_COUNT-1:0] alt_sel
);
   localparam int unsigned NREG   = PIN_COUNT / WORD_W;
   localparam int unsigned NALT   = 2 * NREG;
   localparam int unsigned IDX_W  = $clog2(NALT);
   localparam int unsigned MAP_SZ = 9 * NREG;

   generate
      if (PIN_COUNT != 64 && PIN_COUNT != 96) begin : g_bad_pins
         $error("PIN_COUNT must be 64 or 96");
      end
      if ((1 << ADDR_W) < MAP_SZ) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   grp_e             grp;
   logic [IDX_W-1:0] idx;
   logic             hit, we;
   logic [PIN_COUNT-1:0] level;

   gpio_addr_dec #(.NREG(NREG), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
      .addr (bus_addr),
      .grp  (grp),
      .idx  (idx),
      .hit  (hit)
   );

   assign we = bus_sel && bus_wr && hit;

   gpio_sync #(.WIDTH(PIN_COUNT), .STAGES(2)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .d_out (level)
   );

   gpio_out_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we && grp != GRP_ALT),
      .grp     (grp),
      .idx     (idx),
      .wdata   (bus_wdata),
      .out_vec (pin_out),
      .dir_vec (pin_oe)
   );

   gpio_alt_bank #(.NWORDS(NALT), .IDX_W(IDX_W)) u_alt (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (we && grp == GRP_ALT),
      .idx     (idx),
      .wdata   (bus_wdata),
      .alt_vec (alt_sel)
   );

   always_comb begin
      int unsigned base;
      base      = 32'(idx) * WORD_W;
      bus_rdata = '0;
      if (bus_sel && !bus_wr && hit) begin
         unique case (grp)
            GRP_LEVEL: bus_rdata = level[base +: WORD_W];
            GRP_DIR:   bus_rdata = pin_oe[base +: WORD_W];
            GRP_ALT:   bus_rdata = alt_sel[base +: WORD_W];
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
   parameter int unsigned PIN_COUNT = 64,
   parameter int unsigned ADDR_W    = 5
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_sel,
   input logic                   bus_wr,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [31:0]            bus_wdata,
   input logic [31:0]            bus_rdata,
   input logic [PIN_COUNT-1:0]   pin_in,
   input logic [PIN_COUNT-1:0]   pin_out,
   input logic [PIN_COUNT-1:0]   pin_oe,
   input logic [2*PIN_COUNT-1:0] alt_sel
);
   localparam int unsigned NREG = PIN_COUNT / 32;

   logic wr_acc, rd_acc, edge_grp, strobe_grp;
   assign wr_acc     = bus_sel && bus_wr;
   assign rd_acc     = bus_sel && !bus_wr;
   assign edge_grp   = 32'(bus_addr) >= 4*NREG && 32'(bus_addr) < 7*NREG;
   assign strobe_grp = 32'(bus_addr) >= 2*NREG && 32'(bus_addr) < 4*NREG;

   // R10
   idle_out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_acc |=> $stable(pin_out) && $stable(pin_oe) && $stable(alt_sel));

   // R8
   edge_grp_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_acc && edge_grp) |=> $stable(pin_out) && $stable(pin_oe) && $stable(alt_sel));

   // R5
   strobe_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_acc && strobe_grp) |-> bus_rdata == 32'd0);

   generate
      for (genvar w = 0; w < NREG; w++) begin : g_w
         // R3
         set_bits_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_acc && bus_addr == ADDR_W'(2*NREG + w)) |=>
            ((pin_out[w*32 +: 32] & $past(bus_wdata)) == $past(bus_wdata)));
         // R4
         clr_bits_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_acc && bus_addr == ADDR_W'(3*NREG + w)) |=>
            ((pin_out[w*32 +: 32] & $past(bus_wdata)) == 32'd0));
         // R2
         dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_acc && bus_addr == ADDR_W'(NREG + w)) |=>
            (pin_oe[w*32 +: 32] == $past(bus_wdata)));
      end
   endgenerate
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.PIN_COUNT(PIN_COUNT), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
   localparam int unsigned PINS = 96;
   localparam int unsigned AW   = 5;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_sel = 1'b0, bus_wr = 1'b0;
   logic [AW-1:0]   bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [PINS-1:0] pin_in = '0;
   logic [PINS-1:0] pin_out, pin_oe;
   logic [2*PINS-1:0] alt_sel;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   gpio_bank_ctrl #(.PIN_COUNT(PINS), .ADDR_W(AW)) dut (.*);

   // Row: {is_write, addr[4:0], data[31:0], expected read[31:0], req[3:0]}
   // NREG = 3: dir 3..5, set 6..8, clr 9..11, edge 12..20, alt 21..26.
   localparam int NV = 13;
   localparam logic [73:0] VEC [NV] = '{
      {1'b1, 5'd3,  32'hF0F0_F0F0, 32'h0,         4'd2},  // R2
      {1'b0, 5'd3,  32'h0,         32'hF0F0_F0F0, 4'd2},  // R2
      {1'b1, 5'd6,  32'h0000_00FF, 32'h0,         4'd3},  // R3
      {1'b1, 5'd6,  32'h0000_FF00, 32'h0,         4'd3},  // R3
      {1'b1, 5'd9,  32'h0000_0F0F, 32'h0,         4'd4},  // R4
      {1'b0, 5'd6,  32'h0,         32'h0,         4'd5},  // R5
      {1'b0, 5'd9,  32'h0,         32'h0,         4'd5},  // R5
      {1'b1, 5'd26, 32'h8000_0003, 32'h0,         4'd6},  // R6
      {1'b0, 5'd26, 32'h0,         32'h8000_0003, 4'd6},  // R6
      {1'b1, 5'd12, 32'hFFFF_FFFF, 32'h0,         4'd8},  // R8
      {1'b0, 5'd12, 32'h0,         32'h0,         4'd8},  // R8
      {1'b0, 5'd28, 32'h0,         32'h0,         4'd8},  // R8
      {1'b1, 5'd5,  32'hAAAA_5555, 32'h0,         4'd2}   // R2
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   // All tasks start and end at a falling edge.
   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [PINS-1:0] o_snap, e_snap;
      logic [2*PINS-1:0] a_snap;
      pin_in = 96'hDEAD_BEEF_0123_4567_89AB_CDEF;
      repeat (3) @(negedge clk);
      // R7 reset state
      chk("R7 out", pin_out[31:0] | pin_out[63:32] | pin_out[95:64], 32'h0);
      chk("R7 oe", pin_oe[31:0] | pin_oe[63:32] | pin_oe[95:64], 32'h0);
      chk("R7 alt", 32'(alt_sel != '0), 32'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 level read of all words
      rd(5'd0, r); chk("R1 w0", r, 32'h89AB_CDEF);
      rd(5'd1, r); chk("R1 w1", r, 32'h0123_4567);
      rd(5'd2, r); chk("R1 w2", r, 32'hDEAD_BEEF);

      // table walk
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][73]) wr(VEC[i][72:68], VEC[i][67:36]);
         else begin
            rd(VEC[i][72:68], r);
            chk($sformatf("R%0d row%0d", VEC[i][3:0], i), r, VEC[i][35:4]);
         end
      end
      chk("R3 R4 out w0", pin_out[31:0], 32'h0000_F0F0);
      chk("R2 oe w2", pin_oe[95:64], 32'hAAAA_5555);
      chk("R6 pin80", 32'(alt_sel[161:160]), 32'd3);
      chk("R6 pin95", 32'(alt_sel[191:190]), 32'd2);
      chk("R8 out w1 w2", pin_out[63:32] | pin_out[95:64], 32'h0);

      // R1 level ignores direction and writes
      o_snap = pin_out; e_snap = pin_oe; a_snap = alt_sel;
      wr(5'd0, 32'hFFFF_FFFF);
      chk("R1 write ignored out", 32'(pin_out != o_snap || pin_oe != e_snap || alt_sel != a_snap), 32'h0);
      rd(5'd0, r); chk("R1 level w0 with outputs", r, 32'h89AB_CDEF);

      // R10 reads and idle cycles keep outputs
      rd(5'd3, r); rd(5'd26, r); @(negedge clk);
      chk("R10 stable", 32'(pin_out != o_snap || pin_oe != e_snap || alt_sel != a_snap), 32'h0);

      // R9 back-to-back set then clear of pin 36, and reverse
      wr(5'd7, 32'h10);
      chk("R9 set takes effect", 32'(pin_out[36]), 32'd1);
      wr(5'd10, 32'h10);
      chk("R9 set-clr later wins", 32'(pin_out[36]), 32'd0);
      wr(5'd10, 32'h10); wr(5'd7, 32'h10);
      chk("R9 clr-set later wins", 32'(pin_out[36]), 32'd1);

      // Coincident pin change and set write
      pin_in = 96'h0;
      wr(5'd8, 32'h8000_0001);
      chk("R3 coincident set", pin_out[95:64] & 32'h8000_0001, 32'h8000_0001);
      @(negedge clk);
      rd(5'd2, r); chk("R1 coincident level", r, 32'h0);

      // R7 reset in mid-run
      rst_n = 1'b0; #1;
      chk("R7 mid out", 32'(pin_out != '0), 32'h0);
      chk("R7 mid oe alt", 32'(pin_oe != '0 || alt_sel != '0), 32'h0);
      @(negedge clk); rst_n = 1'b1; @(negedge clk);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule